// File: doc/BRIEF.md
# UART Host Register Interface

This block sits between a host processor and the serial engines of a small UART. The host reaches three registers through a two-bit address, a write strobe, a chip select and one shared bidirectional byte-wide bus. A write can load the byte to be transmitted or the control register. A read returns the received byte, a status byte assembled from the engine flags, or the control register. The block drives the bus only during a selected read and releases it to high impedance at all other times.

The control register holds a receive interrupt enable, a transmit interrupt enable and a three-bit rate code that goes to the baud divider. The block combines the enables with the engine flags into one interrupt request line. A one-cycle load pulse tells the transmitter that a new byte is waiting.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, `tx_data` is 0x00, `tx_load` is 0, `rate_sel` is 0 (code 0 means divide by 26 of the 8 MHz clock, about 38462 baud at 8x sampling), both interrupt enables are 0 and a read of the control register returns 0x00.
- R2: With `cs`=1, `wr`=1 and `addr`=00, the byte on `dbus` is stored at the clock edge. It appears on `tx_data` after that edge, and `tx_load` is 1 for exactly the cycle that follows the edge.
- R3: With `cs`=1, `wr`=0 and `addr`=00, `dbus` carries `rx_data` in the same cycle.
- R4: With `cs`=1, `wr`=0 and `addr`=01, `dbus` carries the status byte: bit 7 is `tx_empty`, bit 6 is `rx_full`, bit 0 is `overrun`, and bits 5 to 1 are 0.
- R5: A write to `addr`=01 changes neither `tx_data` nor the control register, and it does not pulse `tx_load`.
- R6: A write to `addr`=10 or 11 loads the control register. Bit 7 is the transmit interrupt enable, bit 6 is the receive interrupt enable and bits 2:0 are the rate code. The other bits are not stored and read as 0. A read at `addr`=10 or 11 returns the register.
- R7: The block does not drive `dbus` when `cs`=0 or when `wr`=1.
- R8: `irq` is 1 exactly when (receive enable and (`rx_full` or `overrun`)) or (transmit enable and `tx_empty`).
- R9: `rate_sel` always equals bits 2:0 of the control register.
- R10: While `cs`=0, `wr` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| dbus | inout | 8 | Shared host data bus |
| rx_data | input | 8 | Received byte from the receiver |
| tx_empty | input | 1 | Transmit holding register empty |
| rx_full | input | 1 | Received byte waiting |
| overrun | input | 1 | Receive overrun |
| tx_data | output | 8 | Byte held for the transmitter |
| tx_load | output | 1 | One-cycle pulse after a transmit write |
| rate_sel | output | 3 | Baud rate code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a bus that has been released, because high impedance can only be seen indirectly. The bench places a pull-up on every bus bit. Any cycle in which neither side drives must then read 0xFF, and the bench picks status and control values that cannot read as 0xFF, so a read that fails to drive shows up as a wrong value. Writes to the status address and writes with the chip deselected are each followed by a read of the control register and a check of `tx_data`. This shows that nothing was stored.

// File: rtl/uart_hr_pkg.sv
package uart_hr_pkg;
    localparam int DW      = 8;
    localparam int AW      = 2;
    localparam int RATE_W  = 3;
    localparam int TXIE_B  = 7;
    localparam int RXIE_B  = 6;
    localparam logic [RATE_W-1:0] RATE_RST = '0;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_RXD  = 2'd1,
        RD_STAT = 2'd2,
        RD_CTRL = 2'd3
    } rd_sel_t;

    typedef struct packed {
        logic              tx_ie;
        logic              rx_ie;
        logic [RATE_W-1:0] rate;
    } ctrl_t;
endpackage

// File: rtl/uart_hr_decode.sv
module uart_hr_decode
    import uart_hr_pkg::*;
(
    input  logic          cs,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          wr_tdr,
    output logic          wr_ctrl,
    output rd_sel_t       rd_sel
);
    always_comb begin
        wr_tdr  = cs && wr && (addr == 2'b00);
        wr_ctrl = cs && wr && addr[1];
        rd_sel  = RD_NONE;
        if (cs && !wr) begin
            if (addr[1])        rd_sel = RD_CTRL;
            else if (addr[0])   rd_sel = RD_STAT;
            else                rd_sel = RD_RXD;
        end
    end
endmodule

// File: rtl/uart_hr_regs.sv
module uart_hr_regs
    import uart_hr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_tdr,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] tdr,
    output logic          load,
    output ctrl_t         ctrl
);
    typedef struct packed {
        logic [DW-1:0] tdr;
        logic          load;
        ctrl_t         ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = wr_tdr;
        if (wr_tdr)
            st_d.tdr = wdata;
        if (wr_ctrl) begin
            st_d.ctrl.tx_ie = wdata[TXIE_B];
            st_d.ctrl.rx_ie = wdata[RXIE_B];
            st_d.ctrl.rate  = wdata[RATE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ctrl.rate <= RATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdr  = st_q.tdr;
    assign load = st_q.load;
    assign ctrl = st_q.ctrl;

    p_tdr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tdr |=> (tdr == $past(wdata)) && load);
    p_tdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tdr |=> $stable(tdr) && !load);
    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl));
    p_ctrl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl.rate == $past(wdata[RATE_W-1:0])));
endmodule

// File: rtl/uart_hr_irq.sv
module uart_hr_irq
    import uart_hr_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  tx_empty,
    input  logic  rx_full,
    input  logic  overrun,
    output logic  irq
);
    logic rx_src, tx_src;

    always_comb begin
        rx_src = ctrl.rx_ie && (rx_full || overrun);
        tx_src = ctrl.tx_ie && tx_empty;
        irq    = rx_src || tx_src;
    end

    always_comb begin
        if (!ctrl.rx_ie && !ctrl.tx_ie)
            p_irq_masked_r8: assert (!irq);
    end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_hr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       wr,
    input  logic [1:0] addr,
    inout  wire  [7:0] dbus,
    input  logic [7:0] rx_data,
    input  logic       tx_empty,
    input  logic       rx_full,
    input  logic       overrun,
    output logic [7:0] tx_data,
    output logic       tx_load,
    output logic [2:0] rate_sel,
    output logic       irq
);
    logic          wr_tdr, wr_ctrl;
    rd_sel_t       rd_sel;
    ctrl_t         ctrl;
    logic [DW-1:0] rdata;
    logic          drive;

    uart_hr_decode u_dec (
        .cs      (cs),
        .wr      (wr),
        .addr    (addr),
        .wr_tdr  (wr_tdr),
        .wr_ctrl (wr_ctrl),
        .rd_sel  (rd_sel)
    );

    uart_hr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_tdr  (wr_tdr),
        .wr_ctrl (wr_ctrl),
        .wdata   (dbus),
        .tdr     (tx_data),
        .load    (tx_load),
        .ctrl    (ctrl)
    );

    uart_hr_irq u_irq (
        .ctrl     (ctrl),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .overrun  (overrun),
        .irq      (irq)
    );

    always_comb begin
        drive = (rd_sel != RD_NONE);
        rdata = '0;
        unique case (rd_sel)
            RD_RXD:  rdata = rx_data;
            RD_STAT: rdata = {tx_empty, rx_full, 5'b0, overrun};
            RD_CTRL: rdata = {ctrl.tx_ie, ctrl.rx_ie, 3'b0, ctrl.rate};
            default: rdata = '0;
        endcase
    end

    assign dbus     = drive ? rdata : 'z;
    assign rate_sel = ctrl.rate;

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs || wr) |-> !drive);
    p_stat_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 2'b01) |=> $stable(tx_data) && $stable(rate_sel) && !tx_load);
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] rx_data = 8'h00;
    logic       tx_empty = 1'b0, rx_full = 1'b0, overrun = 1'b0;
    logic [7:0] tx_data;
    logic       tx_load;
    logic [2:0] rate_sel;
    logic       irq;
    logic       host_oe = 1'b0;
    logic [7:0] host_val = 8'h00;
    wire  [7:0] dbus;
    int         total = 0, bad = 0;

    assign dbus = host_oe ? host_val : 8'hzz;
    for (genvar g = 0; g < 8; g++) begin : g_pu
        pullup (dbus[g]);
    end

    always #10 clk = ~clk;

    uart_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .dbus(dbus),
        .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
        .tx_data(tx_data), .tx_load(tx_load), .rate_sel(rate_sel), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // fields: [22]cs [21]wr [20:19]addr [18:11]data [10:8]{te,rf,oe} [7:0]bus expected
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1,1'b0,2'b01,8'h00,3'b100,8'h80}, // R4 status tx_empty
        {1'b1,1'b0,2'b01,8'h00,3'b011,8'h41}, // R4 status rx_full+overrun
        {1'b1,1'b0,2'b00,8'hA5,3'b000,8'hA5}, // R3 receive byte
        {1'b1,1'b1,2'b00,8'h3C,3'b000,8'h3C}, // R2 write tx
        {1'b1,1'b1,2'b01,8'h77,3'b000,8'h77}, // R5 write status
        {1'b1,1'b0,2'b10,8'h00,3'b000,8'h00}, // R1 ctrl reset value
        {1'b1,1'b1,2'b10,8'hFF,3'b000,8'hFF}, // R6 write ctrl
        {1'b1,1'b0,2'b11,8'h00,3'b000,8'hC7}, // R6 unused bits read 0
        {1'b1,1'b1,2'b11,8'h45,3'b000,8'h45}, // R6 write via 11
        {1'b1,1'b0,2'b10,8'h00,3'b000,8'h45}, // R6 read back
        {1'b0,1'b0,2'b00,8'h5A,3'b000,8'hFF}, // R7 deselected read released
        {1'b0,1'b1,2'b10,8'h00,3'b000,8'hFF}, // R10 deselected write (host released)
        {1'b1,1'b0,2'b10,8'h00,3'b000,8'h45}  // R10 ctrl unchanged
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tx_empty = 1'b1; rx_full = 1'b1; overrun = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R1 tx_data", tx_data, 8'h00);
        check("R1 tx_load", {7'b0, tx_load}, 8'h00);
        check("R1 rate_sel", {5'b0, rate_sel}, 8'h00);
        check("R8 irq masked at reset", {7'b0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cs = VEC[i][22]; wr = VEC[i][21]; addr = VEC[i][20:19];
            {tx_empty, rx_full, overrun} = VEC[i][10:8];
            if (VEC[i][21] && VEC[i][22]) begin
                host_oe = 1'b1; host_val = VEC[i][18:11];
            end else begin
                host_oe = 1'b0; rx_data = VEC[i][18:11];
            end
            #2;
            check($sformatf("R7 vector %0d bus", i), dbus, VEC[i][7:0]);
        end
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; host_oe = 1'b0; #1;
        check("R5 tx_data after status write", tx_data, 8'h3C);
        check("R9 rate_sel", {5'b0, rate_sel}, 8'h05);
        check("R7 idle bus released", dbus, 8'hFF);

        // R8: ctrl 0x45 -> rx enable only
        {tx_empty, rx_full, overrun} = 3'b010; #1;
        check("R8 rx_full", {7'b0, irq}, 8'h01);
        {tx_empty, rx_full, overrun} = 3'b001; #1;
        check("R8 overrun", {7'b0, irq}, 8'h01);
        {tx_empty, rx_full, overrun} = 3'b100; #1;
        check("R8 tx_empty not enabled", {7'b0, irq}, 8'h00);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = 2'b10; host_oe = 1'b1; host_val = 8'h80;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; host_oe = 1'b0; #1;
        check("R8 tx_empty enabled", {7'b0, irq}, 8'h01);
        check("R9 rate code 0", {5'b0, rate_sel}, 8'h00);
        {tx_empty, rx_full, overrun} = 3'b011; #1;
        check("R8 rx flags not enabled", {7'b0, irq}, 8'h00);

        // R2: load pulse timing
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = 2'b00; host_oe = 1'b1; host_val = 8'h9E; #1;
        check("R2 no pulse before edge", {7'b0, tx_load}, 8'h00);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; host_oe = 1'b0; #1;
        check("R2 pulse", {7'b0, tx_load}, 8'h01);
        check("R2 tx_data", tx_data, 8'h9E);
        @(negedge clk); #1;
        check("R2 pulse one cycle", {7'b0, tx_load}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule